// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block gives a host a two-byte window into a configuration space. The bus offers byte accesses with a one-bit address: address 0 is the index port, address 1 is the data port. A write to the index port picks a register and the data port then reads or writes that register. The window stays closed until a fixed open key has been written to the index port twice in a row. A fixed close key written to the index port closes it again.

Registers below index 0x30 are global and are served inside the block: a logical-device selector, a two-byte device identifier, a revision byte and a two-byte vendor identifier. Indexes 0x30 and above are banked by the selector. The block forwards them to a downstream register file through a register address, a write strobe, write data and a combinational read-data return. The downstream side uses the selector output to choose which device answers. For example, a selector value of 0x06 addresses the general-purpose I/O function.

Top module: `cfg_port`

## Requirements
- R1: After reset the window is closed, the key progress is cleared, the selector output `ld_sel_o` is 0x00 and the index is 0x00.
- R2: Two writes of 0x87 to the index port (address 0) with no other index-port write between them open the window.
- R3: While the window is closed, an index-port write of any value other than 0x87 clears the key progress, so a following single 0x87 does not open the window.
- R4: While the window is closed, reads of either port return 0xFF. Data-port writes (address 1) raise no downstream strobe and leave the selector unchanged.
- R5: While the window is open, an index-port write of 0xAA closes it, and later reads return 0xFF.
- R6: While the window is open, an index-port write of any other value loads the index, and an index-port read returns it.
- R7: A data-port write with index 0x07 loads the selector `ld_sel_o`, and a data-port read at index 0x07 returns it.
- R8: Data-port reads at index 0x20, 0x21 and 0x22 return the device identifier high byte, the device identifier low byte and the revision (defaults 0x05, 0x41, 0x01).
- R9: Data-port reads at index 0x23 and 0x24 return 0x19 and 0x34.
- R10: With the index at 0x30 or above, a data-port write raises `ld_we_o` for that single cycle, with `ld_addr_o` equal to the index and `ld_wdata_o` equal to the written byte. A data-port read returns `ld_rdata_i`.
- R11: A data-port read at an unassigned global index (below 0x30) returns 0x00. A data-port write there raises no strobe and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 1 | 0 = index port, 1 = data port |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 8 | Read byte, valid in the access cycle |
| ld_sel_o | output | 8 | Selected logical device |
| ld_addr_o | output | 8 | Downstream register address (current index) |
| ld_we_o | output | 1 | Downstream write strobe |
| ld_wdata_o | output | 8 | Downstream write byte |
| ld_rdata_i | input | 8 | Downstream read byte, combinational |

## Verification
The assertions assume that each bus access lasts one cycle with `bus_valid_i` high and that the inputs are stable around the sampling edge. They also assume that read data is only meaningful while `bus_valid_i` is high. The stimulus follows these rules: it drives every access on the falling edge, keeps it for exactly one rising edge and drops `bus_valid_i` between accesses. The downstream return is a pure function of `ld_addr_o`, so it stays settled in the same cycle as the read.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned BW = 8;
  localparam logic [BW-1:0] KEY_OPEN    = 8'h87;
  localparam logic [BW-1:0] KEY_CLOSE   = 8'hAA;
  localparam logic [BW-1:0] IDX_LDSEL   = 8'h07;
  localparam logic [BW-1:0] IDX_DEV_HI  = 8'h20;
  localparam logic [BW-1:0] IDX_DEV_LO  = 8'h21;
  localparam logic [BW-1:0] IDX_REV     = 8'h22;
  localparam logic [BW-1:0] IDX_VND_HI  = 8'h23;
  localparam logic [BW-1:0] IDX_VND_LO  = 8'h24;
  localparam logic [BW-1:0] IDX_LD_BASE = 8'h30;
  localparam logic [2*BW-1:0] VENDOR_ID = 16'h1934;
  localparam logic [BW-1:0] CLOSED_READ = 8'hFF;

  typedef enum logic {PORT_INDEX = 1'b0, PORT_DATA = 1'b1} port_sel_e;
endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
  import cfg_port_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_wr_i,
  input  logic [BW-1:0] wdata_i,
  output logic          unlocked_o,
  output logic          armed_o
);
  logic unlocked_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
      armed_q    <= 1'b0;
    end else if (idx_wr_i) begin
      if (!unlocked_q) begin
        if (wdata_i == KEY_OPEN) begin
          unlocked_q <= armed_q;
          armed_q    <= !armed_q;
        end else begin
          armed_q <= 1'b0;
        end
      end else if (wdata_i == KEY_CLOSE) begin
        unlocked_q <= 1'b0;
        armed_q    <= 1'b0;
      end
    end
  end

  assign unlocked_o = unlocked_q;
  assign armed_o    = armed_q;
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
  import cfg_port_pkg::*;
#(
  parameter logic [2*BW-1:0] DEV_ID  = 16'h0541,
  parameter logic [BW-1:0]   DEV_REV = 8'h01
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          unlocked_i,
  input  logic          idx_wr_i,
  input  logic          dat_wr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] index_o,
  output logic [BW-1:0] ld_sel_o,
  output logic [BW-1:0] glob_rdata_o
);
  logic [BW-1:0] index_q, ld_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      index_q  <= '0;
      ld_sel_q <= '0;
    end else if (unlocked_i) begin
      if (idx_wr_i && wdata_i != KEY_CLOSE) index_q <= wdata_i;
      if (dat_wr_i && index_q == IDX_LDSEL) ld_sel_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (index_q)
      IDX_LDSEL:  glob_rdata_o = ld_sel_q;
      IDX_DEV_HI: glob_rdata_o = DEV_ID[2*BW-1:BW];
      IDX_DEV_LO: glob_rdata_o = DEV_ID[BW-1:0];
      IDX_REV:    glob_rdata_o = DEV_REV;
      IDX_VND_HI: glob_rdata_o = VENDOR_ID[2*BW-1:BW];
      IDX_VND_LO: glob_rdata_o = VENDOR_ID[BW-1:0];
      default:    glob_rdata_o = '0;
    endcase
  end

  assign index_o  = index_q;
  assign ld_sel_o = ld_sel_q;
endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0541,
  parameter logic [7:0]  DEV_REV = 8'h01
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_valid_i,
  input  logic       bus_we_i,
  input  logic       bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic [7:0] ld_sel_o,
  output logic [7:0] ld_addr_o,
  output logic       ld_we_o,
  output logic [7:0] ld_wdata_o,
  input  logic [7:0] ld_rdata_i
);
  logic          idx_wr, dat_wr, unlocked, key_armed, is_ld;
  logic [BW-1:0] index, glob_rdata;

  assign idx_wr = bus_valid_i && bus_we_i && (bus_addr_i == PORT_INDEX);
  assign dat_wr = bus_valid_i && bus_we_i && (bus_addr_i == PORT_DATA);

  cfg_key_fsm u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_wr_i   (idx_wr),
    .wdata_i    (bus_wdata_i),
    .unlocked_o (unlocked),
    .armed_o    (key_armed)
  );

  cfg_global_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_glob (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .unlocked_i   (unlocked),
    .idx_wr_i     (idx_wr),
    .dat_wr_i     (dat_wr),
    .wdata_i      (bus_wdata_i),
    .index_o      (index),
    .ld_sel_o     (ld_sel_o),
    .glob_rdata_o (glob_rdata)
  );

  assign is_ld      = index >= IDX_LD_BASE;
  assign ld_addr_o  = index;
  assign ld_wdata_o = bus_wdata_i;
  assign ld_we_o    = dat_wr && unlocked && is_ld;

  always_comb begin
    if (!unlocked)                     bus_rdata_o = CLOSED_READ;
    else if (bus_addr_i == PORT_INDEX) bus_rdata_o = index;
    else if (is_ld)                    bus_rdata_o = ld_rdata_i;
    else                               bus_rdata_o = glob_rdata;
  end
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_valid_i,
  input logic       bus_we_i,
  input logic       bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] bus_rdata_o,
  input logic [7:0] ld_sel_o,
  input logic [7:0] ld_addr_o,
  input logic       ld_we_o,
  input logic       unlocked,
  input logic       key_armed
);
  logic iw, dw;
  assign iw = bus_valid_i && bus_we_i && !bus_addr_i;
  assign dw = bus_valid_i && bus_we_i && bus_addr_i;

  p_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iw && !unlocked && key_armed && bus_wdata_i == 8'h87 |=> unlocked);

  p_progress_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iw && !unlocked && bus_wdata_i != 8'h87 |=> !unlocked && !key_armed);

  p_closed_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_i && !bus_we_i && !unlocked |-> bus_rdata_o == 8'hFF);

  p_no_fwd_closed_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_o |-> unlocked);

  p_close_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iw && unlocked && bus_wdata_i == 8'hAA |=> !unlocked);

  p_sel_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dw && unlocked && ld_addr_o == 8'h07) |=> $stable(ld_sel_o));

  p_fwd_range_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_we_o |-> ld_addr_o >= 8'h30);
endmodule

bind cfg_port cfg_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_valid_i (bus_valid_i),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .ld_sel_o    (ld_sel_o),
  .ld_addr_o   (ld_addr_o),
  .ld_we_o     (ld_we_o),
  .unlocked    (unlocked),
  .key_armed   (key_armed)
);

// File: tb/cfg_port_tb.sv
`timescale 1ns/1ps
module cfg_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, ld_sel, ld_addr, ld_wdata, ld_rdata;
  logic       ld_we;
  int         n_run = 0, n_fail = 0;
  logic       done = 1'b0;
  logic       seen_we;
  logic [7:0] seen_addr, seen_wdata;

  always #4 clk = ~clk;

  assign ld_rdata = ld_addr ^ 8'hC3;

  cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(bus_valid), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .ld_sel_o(ld_sel), .ld_addr_o(ld_addr), .ld_we_o(ld_we),
    .ld_wdata_o(ld_wdata), .ld_rdata_i(ld_rdata)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #2;
    seen_we = ld_we; seen_addr = ld_addr; seen_wdata = ld_wdata;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic open_window();
    wr(1'b0, 8'h87);
    wr(1'b0, 8'h87);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, v);  check("R1 closed after reset", v, 8'hFF);
    check("R1 selector reset", ld_sel, 8'h00);
    check("R1 index reset", ld_addr, 8'h00);
  endtask

  task automatic t_locked_access();
    logic [7:0] v;
    wr(1'b1, 8'h3C);
    check("R4 no strobe while closed", {7'b0, seen_we}, 8'h00);
    check("R4 selector untouched", ld_sel, 8'h00);
    rd(1'b0, v); check("R4 index read closed", v, 8'hFF);
  endtask

  task automatic t_bad_key();
    logic [7:0] v;
    wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    rd(1'b0, v); check("R3 broken key stays closed", v, 8'hFF);
    wr(1'b0, 8'hAA); wr(1'b0, 8'h87);
    rd(1'b1, v); check("R3 single key after clear", v, 8'hFF);
    wr(1'b0, 8'h12);
  endtask

  task automatic t_unlock_index();
    logic [7:0] v;
    open_window();
    wr(1'b0, 8'h5B);
    rd(1'b0, v); check("R2 open after double key", v, 8'h5B);
    check("R6 index drives address", ld_addr, 8'h5B);
    wr(1'b0, 8'h21);
    rd(1'b0, v); check("R6 index reload", v, 8'h21);
  endtask

  task automatic t_ids();
    logic [7:0] v;
    wr(1'b0, 8'h20); rd(1'b1, v); check("R8 device id high", v, 8'h05);
    wr(1'b0, 8'h21); rd(1'b1, v); check("R8 device id low", v, 8'h41);
    wr(1'b0, 8'h22); rd(1'b1, v); check("R8 revision", v, 8'h01);
    wr(1'b0, 8'h23); rd(1'b1, v); check("R9 vendor high", v, 8'h19);
    wr(1'b0, 8'h24); rd(1'b1, v); check("R9 vendor low", v, 8'h34);
  endtask

  task automatic t_ldsel();
    logic [7:0] v;
    wr(1'b0, 8'h07); wr(1'b1, 8'h06);
    check("R7 selector output", ld_sel, 8'h06);
    check("R7 no strobe for global", {7'b0, seen_we}, 8'h00);
    rd(1'b1, v); check("R7 selector readback", v, 8'h06);
  endtask

  task automatic t_forward();
    logic [7:0] v;
    wr(1'b0, 8'h30); wr(1'b1, 8'hE1);
    check("R10 strobe at 0x30", {7'b0, seen_we}, 8'h01);
    check("R10 address", seen_addr, 8'h30);
    check("R10 write data", seen_wdata, 8'hE1);
    @(negedge clk); #2;
    check("R10 strobe one cycle", {7'b0, ld_we}, 8'h00);
    wr(1'b0, 8'hF4); rd(1'b1, v); check("R10 downstream read", v, 8'h37);
  endtask

  task automatic t_global_misc();
    logic [7:0] v;
    wr(1'b0, 8'h2F); rd(1'b1, v); check("R11 unassigned reads zero", v, 8'h00);
    wr(1'b1, 8'h99);
    check("R11 no strobe below 0x30", {7'b0, seen_we}, 8'h00);
    rd(1'b1, v); check("R11 write dropped", v, 8'h00);
    check("R11 selector kept", ld_sel, 8'h06);
  endtask

  task automatic t_relock();
    logic [7:0] v;
    wr(1'b0, 8'hAA);
    rd(1'b1, v); check("R5 closed data read", v, 8'hFF);
    rd(1'b0, v); check("R5 closed index read", v, 8'hFF);
    wr(1'b1, 8'h44);
    check("R4 selector unchanged when closed", ld_sel, 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked_access();
    t_bad_key();
    t_unlock_index();
    t_ids();
    t_ldsel();
    t_forward();
    t_global_misc();
    t_relock();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule